// File: doc/BRIEF.md
# Picture-Edit Micro-Operator Engine

This block turns a stream of numeric source digits into a stream of printable 8-bit characters. A string of one-byte edit operators steers the conversion. Each operator carries an operation code in its high nibble and a variant code in its low nibble. The operators can move digits, suppress leading zeros, insert currency or sign symbols, float a symbol up against the first significant digit, and change the engine's two flags: significance (T) and check-protect (Q). Insertion symbols come from an eight-entry character table that the caller supplies. Some operators take one extra literal byte from the operator stream.

The caller places the operator bytes and the source bytes behind two read-strobe interfaces. `op_byte` and `src_byte` must always show the next unread byte. The engine pulses `op_take` or `src_take` on a clock edge when it consumes the byte shown. The caller pulses `start` to begin, waits for `done`, and collects the characters handshaken on `out_valid`/`out_ready`. `cmp_res` reports whether a non-zero digit was moved, and whether that digit was positive or negative.

The controller has the states IDLE, SIGN, FETCH, EXEC, EMIT and DONE. Its transitions are:
- IDLE goes to SIGN or FETCH on `start`.
- SIGN goes to FETCH after the sign byte is read.
- FETCH goes to EXEC when it reads an operator, or to DONE when the length is used up.
- EXEC goes to EMIT when the operator produces a character, goes back to FETCH for operators that produce no character, or stays on a multi-digit move through EMIT and back to EXEC.
- EMIT goes to its return state on `out_ready`, after it sends any pending float digit.
- DONE goes to IDLE.

Top module: `pic_edit_engine`

## Requirements
- R1: After reset the engine is idle: `busy`=0, `out_valid`=0, `cmp_res`=0. After `start` the engine consumes exactly the number of operator-stream bytes given by `op_len`, which holds two BCD digits (tens in [7:4], ones in [3:0]). Inline literal bytes count toward this length. The engine then pulses `done` and returns to idle.
- R2: Operation 0 moves variant+1 source digits, each emitted as 0x30 plus the low nibble of the source byte. Operation 1 moves variant+1 source bytes unchanged. Both set T.
- R3: Operation 2 handles variant+1 source digits. While T=0, a zero digit emits the fill character, which is blank (0x20) when Q=0 and table entry 2 when Q=1. A non-zero digit, and any digit once T=1, is moved as in operation 0 and sets T.
- R4: Operation 3 emits a symbol chosen by the variant:
  - Variants 0–7 give table entry v, where table entry i is `ins_table[8i+7:8i]`.
  - Variant 8 gives entry 0 when positive and entry 1 when negative.
  - Variant 9 gives blank when positive and entry 1 when negative.
  - Variant A gives entry 0 when positive and blank when negative.
  - Variant B gives the next operator-stream byte as a literal.
  - Variants C–F give blank.
- R5: Operations 4 (positive), 5 (negative) and 6 (T=1) act as operation 3 when their condition holds. Otherwise they emit the fill character. With variant B they always consume the literal byte.
- R6: Operation 7 (float) reads one digit. If T=1 the digit is moved. If T=0 and the digit is non-zero, the engine sets T, emits the variant's symbol, and then emits the digit. If T=0 and the digit is zero, the engine emits fill. With variant B the literal byte is always consumed.
- R7: Operation 8 acts as operation 3 when T=0. When T=1 it emits nothing, but it still consumes the literal byte for variant B.
- R8: Operation 9 controls the flags: variant 0 clears T, variant 1 sets Q, and variant 2 clears Q. Other variants, and operations A–F, emit nothing and change nothing. T and Q are both 0 at `start`.
- R9: With `dst_numeric`=1, every emitted character becomes 0x30 plus its low nibble, so a blank is emitted as 0x30.
- R10: With `src_signed`=1, the first source byte is read as the sign: a low nibble of 0xD means negative, and any other value means positive. This byte is never emitted. With `src_signed`=0 the source is positive.
- R11: `cmp_res` is 0 (equal) at `start`. It becomes 1 for a positive source, or 2 for a negative one, as soon as a non-zero digit is moved.
- R12: At most one character is emitted per clock. While `out_valid`=1 and `out_ready`=0, `out_char` and `out_valid` hold, and no input byte is consumed.
- R13: An `op_len` of 0x00 means 100 operator bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an edit when idle |
| op_len | input | 8 | Operator-string length, two BCD digits, 00 = 100 |
| src_signed | input | 1 | Source starts with a sign byte |
| dst_numeric | input | 1 | Numeric-only destination |
| ins_table | input | 64 | Eight 8-bit insertion symbols, entry i at [8i+7:8i] |
| op_byte | input | 8 | Next unread operator-stream byte |
| op_take | output | 1 | Operator byte consumed at this edge |
| src_byte | input | 8 | Next unread source byte |
| src_take | output | 1 | Source byte consumed at this edge |
| out_char | output | 8 | Emitted character |
| out_valid | output | 1 | `out_char` is valid |
| out_ready | input | 1 | Receiver accepts `out_char` |
| busy | output | 1 | Edit in progress |
| done | output | 1 | One-cycle pulse at the end of the edit |
| cmp_res | output | 2 | 0 equal, 1 high, 2 low |

## Verification
The directed tests target the points where the flags change behaviour:
- Zero suppression is followed by the first significant digit. A design that failed to set T would keep blanking later zeros.
- A float emits two characters from one operator. A design that lost the pending digit would drop it.
- Conditional and end-float operators with variant B skip their literal. A design that failed to skip would execute the literal as an operator and upset the whole string.
- The length is decoded as BCD, with 00 meaning 100. A binary decode would run 18 operators for 0x12, and no operators for 0x00.

A stalled receiver checks that characters are neither duplicated nor lost under backpressure.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SIGN, S_FETCH, S_EXEC, S_EMIT, S_DONE
    } pe_state_t;

    typedef enum logic [1:0] {
        CMP_EQUAL = 2'd0,
        CMP_HIGH  = 2'd1,
        CMP_LOW   = 2'd2
    } cmp_t;

    localparam logic [7:0] CH_BLANK = 8'h20;
    localparam logic [3:0] AV_LIT   = 4'hB;
endpackage

// File: rtl/pe_symbol_sel.sv
module pe_symbol_sel #(
    parameter int CW    = 8,
    parameter int TAB_N = 8
) (
    input  logic [CW*TAB_N-1:0] tab,
    input  logic [3:0]          av,
    input  logic                neg,
    input  logic                q,
    input  logic [CW-1:0]       lit,
    output logic [CW-1:0]       sym,
    output logic [CW-1:0]       fill
);
    import pe_pkg::*;
    localparam int IW = $clog2(TAB_N);
    localparam logic [CW-1:0] BLK = CW'(CH_BLANK);

    logic [CW-1:0] ent [TAB_N];

    for (genvar g = 0; g < TAB_N; g++) begin : g_ent
        assign ent[g] = tab[g*CW +: CW];
    end

    always_comb begin
        unique case (av)
            4'h8:    sym = neg ? ent[1] : ent[0];
            4'h9:    sym = neg ? ent[1] : BLK;
            4'hA:    sym = neg ? BLK : ent[0];
            AV_LIT:  sym = lit;
            default: sym = (int'(av) < TAB_N) ? ent[av[IW-1:0]] : BLK;
        endcase
        fill = q ? ent[2] : BLK;
    end
endmodule

// File: rtl/pe_out_fmt.sv
module pe_out_fmt #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] raw,
    input  logic          numeric,
    output logic [CW-1:0] char_o
);
    assign char_o = numeric ? CW'({4'h3, raw[3:0]}) : raw;
endmodule

// File: rtl/pic_edit_engine.sv
module pic_edit_engine #(
    parameter int CW    = 8,
    parameter int TAB_N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          op_len,
    input  logic                src_signed,
    input  logic                dst_numeric,
    input  logic [CW*TAB_N-1:0] ins_table,
    input  logic [7:0]          op_byte,
    output logic                op_take,
    input  logic [CW-1:0]       src_byte,
    output logic                src_take,
    output logic [CW-1:0]       out_char,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                busy,
    output logic                done,
    output logic [1:0]          cmp_res
);
    import pe_pkg::*;
    localparam int LW = 7;

    pe_state_t st_q, st_n, ret_q, ret_n;
    logic [3:0]    m_q, m_n, av_q, av_n, rep_q, rep_n;
    logic [LW-1:0] left_q, left_n, left_dec, len_dec;
    logic          t_q, t_n, q_q, q_n, neg_q, neg_n, pv_q, pv_n;
    cmp_t          cmp_q, cmp_n, sgn_cmp;
    logic [CW-1:0] ch_q, ch_n, pend_q, pend_n, dchar, sym, fill;
    logic [3:0]    dig;
    logic          cond;

    pe_symbol_sel #(.CW(CW), .TAB_N(TAB_N)) i_sym (
        .tab(ins_table), .av(av_q), .neg(neg_q), .q(q_q),
        .lit(CW'(op_byte)), .sym(sym), .fill(fill)
    );

    pe_out_fmt #(.CW(CW)) i_fmt (
        .raw(ch_q), .numeric(dst_numeric), .char_o(out_char)
    );

    assign dig      = src_byte[3:0];
    assign dchar    = CW'({4'h3, dig});
    assign sgn_cmp  = neg_q ? CMP_LOW : CMP_HIGH;
    assign len_dec  = (op_len == 8'h00) ? LW'(100)
                    : LW'(op_len[7:4]) * LW'(10) + LW'(op_len[3:0]);
    assign left_dec = (left_q != '0) ? left_q - 1'b1 : '0;
    assign cond     = (m_q == 4'd3) || (m_q == 4'd4 && !neg_q) ||
                      (m_q == 4'd5 && neg_q) || (m_q == 4'd6 && t_q);

    always_comb begin
        st_n = st_q;  ret_n = ret_q; m_n = m_q; av_n = av_q; rep_n = rep_q;
        left_n = left_q; t_n = t_q; q_n = q_q; neg_n = neg_q; cmp_n = cmp_q;
        ch_n = ch_q; pend_n = pend_q; pv_n = pv_q;
        op_take = 1'b0; src_take = 1'b0;
        unique case (st_q)
            S_IDLE: if (start) begin
                left_n = len_dec; t_n = 1'b0; q_n = 1'b0; neg_n = 1'b0;
                cmp_n = CMP_EQUAL; pv_n = 1'b0;
                st_n = src_signed ? S_SIGN : S_FETCH;
            end
            S_SIGN: begin
                src_take = 1'b1;
                neg_n = (dig == 4'hD);
                st_n = S_FETCH;
            end
            S_FETCH: begin
                if (left_q == '0) st_n = S_DONE;
                else begin
                    op_take = 1'b1;
                    m_n = op_byte[7:4]; av_n = op_byte[3:0]; rep_n = op_byte[3:0];
                    left_n = left_dec;
                    st_n = S_EXEC;
                end
            end
            S_EXEC: begin
                ret_n = S_FETCH;
                unique case (m_q)
                    4'd0, 4'd1, 4'd2: begin
                        src_take = 1'b1;
                        if (m_q == 4'd2 && !t_q && dig == 4'd0) ch_n = fill;
                        else begin
                            t_n  = 1'b1;
                            ch_n = (m_q == 4'd1) ? src_byte : dchar;
                            if (dig != 4'd0) cmp_n = sgn_cmp;
                        end
                        if (rep_q != 4'd0) begin
                            rep_n = rep_q - 1'b1; ret_n = S_EXEC;
                        end
                        st_n = S_EMIT;
                    end
                    4'd3, 4'd4, 4'd5, 4'd6: begin
                        if (av_q == AV_LIT) begin op_take = 1'b1; left_n = left_dec; end
                        ch_n = cond ? sym : fill;
                        st_n = S_EMIT;
                    end
                    4'd7: begin
                        src_take = 1'b1;
                        if (av_q == AV_LIT) begin op_take = 1'b1; left_n = left_dec; end
                        if (t_q) begin
                            ch_n = dchar;
                            if (dig != 4'd0) cmp_n = sgn_cmp;
                        end else if (dig != 4'd0) begin
                            t_n = 1'b1; cmp_n = sgn_cmp;
                            ch_n = sym; pend_n = dchar; pv_n = 1'b1;
                        end else ch_n = fill;
                        st_n = S_EMIT;
                    end
                    4'd8: begin
                        if (av_q == AV_LIT) begin op_take = 1'b1; left_n = left_dec; end
                        ch_n = sym;
                        st_n = t_q ? S_FETCH : S_EMIT;
                    end
                    4'd9: begin
                        unique case (av_q)
                            4'd0:    t_n = 1'b0;
                            4'd1:    q_n = 1'b1;
                            4'd2:    q_n = 1'b0;
                            default: ;
                        endcase
                        st_n = S_FETCH;
                    end
                    default: st_n = S_FETCH;
                endcase
            end
            S_EMIT: if (out_ready) begin
                if (pv_q) begin ch_n = pend_q; pv_n = 1'b0; end
                else st_n = ret_q;
            end
            S_DONE: st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE; ret_q <= S_FETCH; m_q <= '0; av_q <= '0; rep_q <= '0;
            left_q <= '0; t_q <= 1'b0; q_q <= 1'b0; neg_q <= 1'b0; cmp_q <= CMP_EQUAL;
            ch_q <= '0; pend_q <= '0; pv_q <= 1'b0;
        end else begin
            st_q <= st_n; ret_q <= ret_n; m_q <= m_n; av_q <= av_n; rep_q <= rep_n;
            left_q <= left_n; t_q <= t_n; q_q <= q_n; neg_q <= neg_n; cmp_q <= cmp_n;
            ch_q <= ch_n; pend_q <= pend_n; pv_q <= pv_n;
        end
    end

    assign out_valid = (st_q == S_EMIT);
    assign busy      = (st_q != S_IDLE);
    assign done      = (st_q == S_DONE);
    assign cmp_res   = cmp_q;

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_char));
    assert_no_take_in_emit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !op_take && !src_take);
    assert_cmp_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && start) |=> cmp_res == CMP_EQUAL);
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_move_sets_t_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC && m_q == 4'd0) |=> t_q);
endmodule

// File: tb/test_pic_edit_engine.sv
`timescale 1ns/1ps
module test_pic_edit_engine;
    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, src_signed = 1'b0, dst_numeric = 1'b0;
    logic [7:0] op_len = 8'h01;
    logic [63:0] ins_table;
    logic [7:0] op_byte, src_byte, out_char;
    logic op_take, src_take, out_valid, out_ready = 1'b1, busy, done;
    logic [1:0] cmp_res;

    logic [7:0] ops [0:127];
    logic [7:0] srcs [0:127];
    logic [7:0] got [0:127];
    logic [7:0] op_idx = 0, src_idx = 0;
    int got_n = 0;
    logic clr = 1'b0, stall = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    // table: 0 '+', 1 '-', 2 '*', 3 '$', 4 ',', 5 '.', 6 'C', 7 'R'
    assign ins_table = {8'h52, 8'h43, 8'h2E, 8'h2C, 8'h24, 8'h2A, 8'h2D, 8'h2B};
    assign op_byte  = ops[op_idx[6:0]];
    assign src_byte = srcs[src_idx[6:0]];

    pic_edit_engine i_pic_edit_engine (
        .clk, .rst_n, .start, .op_len, .src_signed, .dst_numeric, .ins_table,
        .op_byte, .op_take, .src_byte, .src_take, .out_char, .out_valid,
        .out_ready, .busy, .done, .cmp_res
    );

    always @(posedge clk) begin
        if (clr) begin
            op_idx <= 0; src_idx <= 0; got_n <= 0;
        end else begin
            if (op_take)  op_idx  <= op_idx + 1;
            if (src_take) src_idx <= src_idx + 1;
            if (out_valid && out_ready) begin got[got_n[6:0]] <= out_char; got_n <= got_n + 1; end
        end
    end

    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= stall ? lfsr[0] : 1'b1;
    end

    task automatic check(input string req, input bit ok, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] o[], input logic [7:0] s[]);
        for (int i = 0; i < 128; i++) begin ops[i] = 8'h99; srcs[i] = 8'h00; end
        foreach (o[i]) ops[i] = o[i];
        foreach (s[i]) srcs[i] = s[i];
    endtask

    task automatic run(input logic [7:0] len, input logic sgn, input logic num);
        int n = 0;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        op_len = len; src_signed = sgn; dst_numeric = num; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        if (n >= 5000) check("R1", 1'b0, "no done", "done");
        @(negedge clk);
    endtask

    function automatic string got_str();
        string s = "";
        for (int i = 0; i < got_n; i++) s = $sformatf("%s%c", s, got[i]);
        return s;
    endfunction

    task automatic expect_str(input string req, input string exp);
        bit ok = (got_n == exp.len());
        for (int i = 0; i < exp.len() && i < got_n; i++) if (got[i] != exp[i]) ok = 0;
        check(req, ok, {"\"", got_str(), "\""}, {"\"", exp, "\""});
    endtask

    task automatic expect_cmp(input string req, input logic [1:0] e);
        check(req, cmp_res == e, $sformatf("%0d", cmp_res), $sformatf("%0d", e));
    endtask

    task automatic t_reset();
        check("R1", !busy && !out_valid && cmp_res == 2'd0,
              $sformatf("busy=%0d valid=%0d cmp=%0d", busy, out_valid, cmp_res), "0 0 0");
    endtask

    task automatic t_move();
        load('{8'h02}, '{8'h01, 8'h02, 8'h03}); run(8'h01, 0, 0);
        expect_str("R2 digits", "123"); expect_cmp("R11 high", 2'd1);
        load('{8'h11}, '{8'h41, 8'h42}); run(8'h01, 0, 0);
        expect_str("R2 chars", "AB");
    endtask

    task automatic t_suppress();
        load('{8'h23}, '{8'h00, 8'h00, 8'h04, 8'h05}); run(8'h01, 0, 0);
        expect_str("R3 blank", "  45");
        load('{8'h22}, '{8'h0D, 8'h00, 8'h00, 8'h07}); run(8'h01, 1, 0);
        expect_str("R10 sign skipped", "  7"); expect_cmp("R11 low", 2'd2);
        load('{8'h91, 8'h23}, '{8'h00, 8'h00, 8'h00, 8'h05}); run(8'h02, 0, 0);
        expect_str("R3 check-protect", "***5");
        load('{8'h21}, '{8'h00, 8'h00}); run(8'h01, 0, 0);
        expect_str("R3 all zero", "  "); expect_cmp("R11 equal", 2'd0);
    endtask

    task automatic t_insert();
        load('{8'h33, 8'h38, 8'h3B, 8'h58, 8'h39, 8'h3A, 8'h37}, '{8'h00}); run(8'h07, 0, 0);
        expect_str("R4 plus", "$+X +R");
        load('{8'h38, 8'h39, 8'h3A}, '{8'h0D}); run(8'h03, 1, 0);
        expect_str("R4 minus", "-- ");
    endtask

    task automatic t_cond();
        load('{8'h64, 8'h6B, 8'h5A, 8'h00, 8'h64}, '{8'h09}); run(8'h05, 0, 0);
        expect_str("R5 on T", "  9,");
        load('{8'h4B, 8'h50, 8'h5B, 8'h4D, 8'h48, 8'h58}, '{8'h0D}); run(8'h06, 1, 0);
        expect_str("R5 on sign", " M -");
    endtask

    task automatic t_float();
        load('{8'h73, 8'h73, 8'h73}, '{8'h00, 8'h01, 8'h02}); run(8'h03, 0, 0);
        expect_str("R6 float", " $12"); expect_cmp("R11 float", 2'd1);
        load('{8'h91, 8'h73, 8'h73}, '{8'h00, 8'h05}); run(8'h03, 0, 0);
        expect_str("R6 float Q", "*$5");
        load('{8'h7B, 8'h23}, '{8'h03}); run(8'h02, 0, 0);
        expect_str("R6 float literal", "#3");
    endtask

    task automatic t_endfloat();
        load('{8'h73, 8'h73, 8'h83}, '{8'h00, 8'h00}); run(8'h03, 0, 0);
        expect_str("R7 T=0", "  $");
        load('{8'h00, 8'h83}, '{8'h04}); run(8'h02, 0, 0);
        expect_str("R7 T=1", "4");
        load('{8'h00, 8'h8B, 8'h51, 8'h00}, '{8'h01, 8'h02}); run(8'h04, 0, 0);
        expect_str("R7 skip literal", "12");
    endtask

    task automatic t_control();
        load('{8'h00, 8'h90, 8'h21}, '{8'h05, 8'h00, 8'h00}); run(8'h03, 0, 0);
        expect_str("R8 clear T", "5  ");
        load('{8'h91, 8'h92, 8'hA5, 8'h97, 8'h21}, '{8'h00, 8'h00}); run(8'h05, 0, 0);
        expect_str("R8 clear Q and no-ops", "  ");
    endtask

    task automatic t_numeric();
        load('{8'h23}, '{8'h00, 8'h00, 8'h03, 8'h04}); run(8'h01, 0, 1);
        expect_str("R9 numeric", "0034");
    endtask

    task automatic t_length();
        string e = "";
        load('{8'h30}, '{8'h00});
        for (int i = 0; i < 128; i++) ops[i] = 8'h30;
        run(8'h12, 0, 0);
        expect_str("R1 bcd length", "++++++++++++");
        for (int i = 0; i < 100; i++) e = {e, "+"};
        run(8'h00, 0, 0);
        expect_str("R13 hundred", e);
        check("R13 bytes read", op_idx == 8'd100, $sformatf("%0d", op_idx), "100");
    endtask

    task automatic t_stall();
        stall = 1'b1;
        load('{8'h73, 8'h73, 8'h73, 8'h02}, '{8'h00, 8'h01, 8'h02, 8'h07, 8'h08, 8'h09});
        run(8'h04, 0, 0);
        expect_str("R12 backpressure", " $12789");
        stall = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_move(); t_suppress(); t_insert(); t_cond(); t_float();
        t_endfloat(); t_control(); t_numeric(); t_length(); t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule